// File: doc/BRIEF.md
# Cascaded Serial Clock Divider

This block derives the serial clock of an SPI master from a fast main clock. The main clock first passes through a power-of-two stage, whose ratio is set by a 2-bit exponent field. A 6-bit integer field then sets a further division. The result is a square serial clock whose full period is `(2 << div_sel) * 2 * (brg + 1)` main-clock cycles. The block also produces two registered strobes, each one main-clock cycle wide, that mark the leading and trailing edges of the serial clock. A shift engine uses them to sample and launch data.

The integer field has a floor. Any programmed value below 4 is treated as 4, so the fastest ratio is main/20 and the slowest is main/2048. Both fields and the idle polarity are captured while `en` is low and held for as long as `en` stays high. A new setting therefore takes effect only when the clock is next enabled. Lowering `en` clears both counters and returns the serial clock to its idle level.

Top module: `spi_clk_prescaler`

## Requirements
- R1: During and right after reset, with `en` low, `sclk` equals `idle_pol` and both strobes are 0.
- R2: Counting the first main-clock edge that samples `en` high as edge 1, `sclk` changes level at edges H, 2H, 3H and so on, where H = `(2 << div_sel) * (brg + 1)`. One full serial period is therefore 2H main cycles.
- R3: A `brg` value of 0, 1, 2 or 3 gives the same timing as `brg` = 4.
- R4: `div_sel`=0 with `brg`=4 gives a period of 20 main cycles. `div_sel`=3 with `brg`=63 gives a period of 2048 main cycles.
- R5: While `en` is low, `sclk` equals `idle_pol`. From the second edge that samples `en` low onward, both strobes are 0.
- R6: `lead_stb` is 1 for exactly the main cycle after the edge where `sclk` leaves its idle level (edges H, 3H, ...). `trail_stb` is 1 for exactly the main cycle after the edge where `sclk` returns to idle (edges 2H, 4H, ...). The two strobes are never 1 together.
- R7: A change to `div_sel`, `brg` or `idle_pol` while `en` stays high does not change the output timing or level. The new value applies after `en` has been low for at least one edge and is raised again.
- R8: Lowering `en` in the middle of a period clears both divider counters. After re-enable, the first `sclk` change again comes at edge H.
- R9: With `idle_pol`=1, `sclk` rests high, its first change after enable is a fall, and `lead_stb` marks that fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run the divider; low holds it idle and captures settings |
| div_sel | input | 2 | Power-of-two stage exponent, ratio 2 << div_sel |
| brg | input | 6 | Integer stage setting, ratio 2*(brg+1), floor 4 |
| idle_pol | input | 1 | Level of sclk when idle |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the leading sclk edge |
| trail_stb | output | 1 | One-cycle strobe on the trailing sclk edge |

## Verification
A prescale counter that wraps at the wrong value, or a second-stage counter that ignores the floor, would move the first sclk change away from edge H. That error is visible at the first edge of the first period. A configuration register that follows its input while running would show up at the port as a period that changes size mid-run, within one half period of the change. A phase or strobe register that is not cleared on disable would show up as a late first edge, or as a missing or inverted leading strobe, at the first edge after re-enable.

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler #(
  parameter int DIV_W   = 2,
  parameter int BRG_W   = 6,
  parameter int BRG_MIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [BRG_W-1:0] brg,
  input  logic             idle_pol,
  output logic             sclk,
  output logic             lead_stb,
  output logic             trail_stb
);
  localparam int PRE_W = (1 << DIV_W) + 1;

  logic [DIV_W-1:0] div_q;
  logic [BRG_W-1:0] brg_q;
  logic             pol_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [BRG_W-1:0] brg_cnt;
  logic             phase_q;

  wire [BRG_W-1:0] brg_clamped = (brg < BRG_W'(BRG_MIN)) ? BRG_W'(BRG_MIN) : brg;
  wire [PRE_W-1:0] pre_max     = (PRE_W'(2) << div_q) - PRE_W'(1);
  wire             pre_tick    = (pre_cnt == pre_max);
  wire             toggle      = pre_tick && (brg_cnt == brg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q     <= '0;
      brg_q     <= BRG_W'(BRG_MIN);
      pol_q     <= 1'b0;
      pre_cnt   <= '0;
      brg_cnt   <= '0;
      phase_q   <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else if (!en) begin
      div_q     <= div_sel;
      brg_q     <= brg_clamped;
      pol_q     <= idle_pol;
      pre_cnt   <= '0;
      brg_cnt   <= '0;
      phase_q   <= 1'b0;
      lead_stb  <= 1'b0;
      trail_stb <= 1'b0;
    end else begin
      pre_cnt   <= pre_tick ? '0 : pre_cnt + PRE_W'(1);
      if (pre_tick) brg_cnt <= toggle ? '0 : brg_cnt + BRG_W'(1);
      if (toggle) phase_q <= ~phase_q;
      lead_stb  <= toggle && !phase_q;
      trail_stb <= toggle && phase_q;
    end
  end

  assign sclk = en ? (phase_q ^ pol_q) : idle_pol;

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_stb && trail_stb));

  p_lead_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lead_stb |=> !lead_stb);

  p_trail_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trail_stb |=> !trail_stb);

  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !$past(en)) |-> (!lead_stb && !trail_stb));

  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> ($stable(div_q) && $stable(brg_q) && $stable(pol_q)));

  p_brg_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    brg_q >= BRG_W'(BRG_MIN));

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    brg_cnt <= brg_q);
endmodule

// File: tb/spi_clk_prescaler_tb.sv
module spi_clk_prescaler_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] div_sel = '0;
  logic [5:0] brg = 6'd4;
  logic       idle_pol = 1'b0;
  logic       sclk, lead_stb, trail_stb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  spi_clk_prescaler u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel), .brg(brg),
    .idle_pol(idle_pol), .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: {sclk,lead,trail} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [1:0] d, input logic [5:0] b, input logic p);
    @(negedge clk);
    en = 1'b0; div_sel = d; brg = b; idle_pol = p;
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic watch(input int h, input logic p, input int n, input string tag);
    for (int c = 1; c <= n; c++) begin
      logic [2:0] e;
      @(posedge clk);
      @(negedge clk);
      e[2] = p ^ logic'((c / h) % 2);
      e[1] = (c % h == 0) && ((c / h) % 2 == 1);
      e[0] = (c % h == 0) && ((c / h) % 2 == 0);
      check({sclk, lead_stb, trail_stb} == e, tag, {sclk, lead_stb, trail_stb}, e);
    end
  endtask

  task automatic t_reset;
    #(CLK_PERIOD * 2 + 1);
    check({sclk, lead_stb, trail_stb} == 3'b000, "R1 in reset", {sclk, lead_stb, trail_stb}, 3'b000);
    idle_pol = 1'b1;
    #1;
    check(sclk == 1'b1, "R1 idle follows pol", {sclk, 2'b00}, 3'b100);
    idle_pol = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({sclk, lead_stb, trail_stb} == 3'b000, "R1 after reset", {sclk, lead_stb, trail_stb}, 3'b000);
  endtask

  task automatic t_fastest;
    setup(2'd0, 6'd4, 1'b0);
    watch(10, 1'b0, 45, "R4 fastest R2 R6");
  endtask

  task automatic t_mid;
    setup(2'd1, 6'd9, 1'b0);
    watch(40, 1'b0, 170, "R2 div1 brg9");
    setup(2'd2, 6'd5, 1'b0);
    watch(48, 1'b0, 100, "R2 div2 brg5");
  endtask

  task automatic t_floor;
    setup(2'd0, 6'd0, 1'b0);
    watch(10, 1'b0, 41, "R3 brg0");
    setup(2'd1, 6'd3, 1'b0);
    watch(20, 1'b0, 41, "R3 brg3");
  endtask

  task automatic t_slowest;
    setup(2'd3, 6'd63, 1'b0);
    watch(1024, 1'b0, 2050, "R4 slowest");
  endtask

  task automatic t_polarity;
    setup(2'd0, 6'd4, 1'b1);
    watch(10, 1'b1, 41, "R9 idle high");
  endtask

  task automatic t_hold_cfg;
    setup(2'd0, 6'd4, 1'b0);
    watch(10, 1'b0, 5, "R7 before change");
    div_sel = 2'd3; brg = 6'd63; idle_pol = 1'b1;
    for (int c = 6; c <= 40; c++) begin
      logic [2:0] e;
      @(posedge clk);
      @(negedge clk);
      e[2] = logic'((c / 10) % 2);
      e[1] = (c % 10 == 0) && ((c / 10) % 2 == 1);
      e[0] = (c % 10 == 0) && ((c / 10) % 2 == 0);
      check({sclk, lead_stb, trail_stb} == e, "R7 change ignored", {sclk, lead_stb, trail_stb}, e);
    end
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    watch(1024, 1'b1, 1030, "R7 applied on re-enable");
  endtask

  task automatic t_restart;
    setup(2'd0, 6'd4, 1'b0);
    watch(10, 1'b0, 15, "R8 run");
    en = 1'b0;
    #1;
    check(sclk == 1'b0, "R5 idle on disable", {sclk, 2'b00}, 3'b000);
    @(negedge clk);
    @(negedge clk);
    check({sclk, lead_stb, trail_stb} == 3'b000, "R5 disabled quiet", {sclk, lead_stb, trail_stb}, 3'b000);
    en = 1'b1;
    watch(10, 1'b0, 25, "R8 restart");
  endtask

  initial begin
    t_reset();
    t_fastest();
    t_mid();
    t_floor();
    t_slowest();
    t_polarity();
    t_hold_cfg();
    t_restart();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule